// File: doc/BRIEF.md
# Power-good reset timer

This block produces an active-low system reset from the regulation status of two supply rails: a 3.3 V rail and a 5 V rail. The reset output stays asserted (low) until every rail being watched reports that it is in regulation. After that, a counter counts oscillator ticks. The reset is released only when a fixed number of ticks has passed. While the count is running, a busy flag is high.

The block runs in one of two modes. In normal mode it watches both rails. In independent mode it watches only the 3.3 V rail, and the 5 V flag has no effect. A global enable input forces the reset low and clears the count. This covers both the disabled state and shutdown.

The timeout counts ticks, not system clocks. With the default of 32,000 ticks, the delay is about 107 ms at a 300 kHz tick rate and about 160 ms at 200 kHz. The tick input is a single-clock pulse, one pulse per oscillator cycle.

Top module: `pgood_reset_gen`

## Requirements
- R1: Reset state: while `rst_n` is low, and on the first cycle after it rises, `rst_out_n` is 0 and `busy` is 0.
- R2: With `enable` high, if any watched rail flag is 0, `rst_out_n` is 0 and `busy` is 0 one clock later. Ticks do not advance the count in this state.
- R3: In the clock after all watched flags (and `enable`) are 1, `busy` becomes 1. The count advances by one only on clocks where `tick` is 1. Clocks without a tick leave the count unchanged.
- R4: `rst_out_n` rises, and `busy` falls, on the clock edge that samples the TIMEOUT_TICKS-th tick. After TIMEOUT_TICKS-1 ticks, `rst_out_n` is still 0. TIMEOUT_TICKS defaults to 32000.
- R5: When `indep_mode` is 1, only `rail3_ok` is watched. The value of `rail5_ok` does not affect `rst_out_n` or `busy`.
- R6: When `indep_mode` is 0, `rail3_ok` and `rail5_ok` must both be 1 before any counting takes place.
- R7: If a watched rail drops out while the count is running, the count returns to zero. After the rail recovers, a full TIMEOUT_TICKS ticks are needed again.
- R8: If a watched rail drops out after release, `rst_out_n` returns to 0 on the next clock. A full new timeout is then needed before release.
- R9: When `enable` is 0, `rst_out_n` and `busy` are 0 on the next clock and the count clears. After `enable` returns to 1, a full timeout is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| enable | input | 1 | Global enable; 0 means disabled or shutdown |
| indep_mode | input | 1 | 1 = watch only the 3.3 V rail |
| rail3_ok | input | 1 | 3.3 V rail is in regulation |
| rail5_ok | input | 1 | 5 V rail is in regulation |
| tick | input | 1 | One-clock pulse per oscillator cycle |
| rst_out_n | output | 1 | Active-low system reset; 1 = released |
| busy | output | 1 | Timeout count is running |

## Verification
The only observable sign of the internal count is the exact tick on which `rst_out_n` rises. A counter that has stalled, been preloaded, or was not cleared therefore shows up as a release one tick early or late. For this reason the bench checks the output both after TIMEOUT_TICKS-1 ticks and after TIMEOUT_TICKS ticks.

A clear that is missing after a dropout, a disable, or a release shows up only on the next qualification, again as an early release. Each such case is therefore followed by a full recount. A wrong rail selection shows up within one clock, as `busy` or `rst_out_n` taking the wrong value.

// File: rtl/pg_reset_pkg.sv
package pg_reset_pkg;

    typedef struct packed {
        logic released;
        logic running;
    } pg_state_t;

endpackage

// File: rtl/pg_rail_select.sv
module pg_rail_select (
    input  logic enable,
    input  logic indep_mode,
    input  logic rail3_ok,
    input  logic rail5_ok,
    output logic mon_ok
);

    logic need5;

    always_comb begin
        // the 5 V flag only counts when not in independent mode (R5, R6)
        need5  = ~indep_mode;
        mon_ok = enable & rail3_ok & (rail5_ok | ~need5);
    end

endmodule

// File: rtl/pg_tick_timer.sv
module pg_tick_timer #(
    parameter int TICKS = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expire
);

    localparam int W = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the count never goes past the terminal value
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: a clear request empties the count on the next edge
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R3: without a tick, the count holds
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/pgood_reset_gen.sv
module pgood_reset_gen #(
    parameter int TIMEOUT_TICKS = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic indep_mode,
    input  logic rail3_ok,
    input  logic rail5_ok,
    input  logic tick,
    output logic rst_out_n,
    output logic busy
);
    import pg_reset_pkg::*;

    logic      mon_ok;
    logic      expire;
    logic      timer_clear;
    pg_state_t st_d, st_q;

    pg_rail_select u_sel (
        .enable     (enable),
        .indep_mode (indep_mode),
        .rail3_ok   (rail3_ok),
        .rail5_ok   (rail5_ok),
        .mon_ok     (mon_ok)
    );

    assign timer_clear = ~mon_ok | st_q.released;

    pg_tick_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .tick   (tick),
        .expire (expire)
    );

    always_comb begin
        st_d          = st_q;
        st_d.released = mon_ok & (st_q.released | expire);
        st_d.running  = mon_ok & ~st_d.released;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_out_n = st_q.released;
    assign busy      = st_q.running;

    // R9: disable forces reset low and stops the count
    p_disable_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rst_out_n && !busy));

    // R6: in normal mode a missing 5 V flag holds reset
    p_need_rail5_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!indep_mode && !rail5_ok) |=> !rst_out_n);

    // R2: a missing 3.3 V flag always holds reset
    p_need_rail3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rail3_ok |=> (!rst_out_n && !busy));

    // R4: release only follows a tick sampled while counting
    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(tick) && $past(busy)));

    // R4: counting and released never coexist
    p_busy_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && rst_out_n));

endmodule

// File: tb/sim_pgood_reset_gen.sv
`timescale 1ns/1ps
module sim_pgood_reset_gen;

    localparam int TOUT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic indep_mode = 1'b0;
    logic rail3_ok = 1'b0;
    logic rail5_ok = 1'b0;
    logic tick = 1'b0;
    logic rst_out_n, busy;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pgood_reset_gen #(.TIMEOUT_TICKS(TOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .indep_mode(indep_mode),
        .rail3_ok(rail3_ok), .rail5_ok(rail5_ok), .tick(tick),
        .rst_out_n(rst_out_n), .busy(busy)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_in(input logic en, input logic ind, input logic r3, input logic r5);
        @(negedge clk);
        enable = en; indep_mode = ind; rail3_ok = r3; rail5_ok = r5;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(rst_out_n, 1'b0, "R1 rst_out_n during reset");
        chk(busy, 1'b0, "R1 busy during reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(rst_out_n, 1'b0, "R1 rst_out_n after reset");
        chk(busy, 1'b0, "R1 busy after reset");
    endtask

    task automatic t_missing_rail();
        set_in(1'b1, 1'b0, 1'b1, 1'b0);
        chk(busy, 1'b0, "R6 busy with 5V flag low");
        ticks(TOUT + 5);
        chk(rst_out_n, 1'b0, "R6 reset held with 5V flag low");
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        ticks(TOUT + 5);
        chk(rst_out_n, 1'b0, "R2 reset held with 3V flag low");
        chk(busy, 1'b0, "R2 busy with 3V flag low");
    endtask

    task automatic t_full_count();
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        chk(busy, 1'b1, "R3 busy after qualification");
        idle(7);
        chk(busy, 1'b1, "R3 still busy without ticks");
        ticks(TOUT - 1);
        chk(rst_out_n, 1'b0, "R4 not released at TOUT-1 (R3 idle clocks ignored)");
        ticks(1);
        chk(rst_out_n, 1'b1, "R4 released at TOUT");
        chk(busy, 1'b0, "R4 busy falls at release");
        ticks(3);
        chk(rst_out_n, 1'b1, "R4 stays released");
    endtask

    task automatic t_drop_after();
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        chk(rst_out_n, 1'b0, "R8 reset low after dropout");
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        ticks(TOUT - 1);
        chk(rst_out_n, 1'b0, "R8 full recount needed");
        ticks(1);
        chk(rst_out_n, 1'b1, "R8 released after recount");
    endtask

    task automatic t_drop_during();
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        ticks(12);
        set_in(1'b1, 1'b0, 1'b1, 1'b0);
        chk(busy, 1'b0, "R7 busy drops on dropout");
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        ticks(TOUT - 1);
        chk(rst_out_n, 1'b0, "R7 count restarted from zero");
        ticks(1);
        chk(rst_out_n, 1'b1, "R7 released after full count");
    endtask

    task automatic t_indep();
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        ticks(2);
        chk(rst_out_n, 1'b1, "R5 5V flag ignored when released");
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        chk(rst_out_n, 1'b0, "R5 3V flag still watched");
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        chk(busy, 1'b1, "R5 counting with 5V flag low");
        ticks(5);
        rail5_ok = 1'b1; idle(1);
        rail5_ok = 1'b0; idle(1);
        ticks(TOUT - 6);
        chk(rst_out_n, 1'b0, "R5 toggling 5V did not disturb count");
        ticks(1);
        chk(rst_out_n, 1'b1, "R5 released on 3V alone");
    endtask

    task automatic t_disable();
        set_in(1'b0, 1'b0, 1'b1, 1'b1);
        chk(rst_out_n, 1'b0, "R9 reset forced low");
        chk(busy, 1'b0, "R9 busy low when disabled");
        ticks(TOUT + 2);
        chk(rst_out_n, 1'b0, "R9 no count while disabled");
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        ticks(8);
        set_in(1'b0, 1'b0, 1'b1, 1'b1);
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        ticks(TOUT - 1);
        chk(rst_out_n, 1'b0, "R9 count cleared by disable");
        ticks(1);
        chk(rst_out_n, 1'b1, "R9 released after full count");
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(2);
        t_reset();
        t_missing_rail();
        t_full_count();
        t_drop_after();
        t_drop_during();
        t_indep();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule